// File: doc/BRIEF.md
# Snoop-Aware Slave Address Router

This block sits where requests from other on-chip bus masters enter the processor's memory space. Each request carries a 32-bit address and a read/write flag. The router sends it down exactly one of three request channels:

- **Snoop channel.** The request goes unchanged to the processor I/O bus, so the processor cache sees it and stays coherent.
- **Memory-controller channel.**
- **On-chip-bus channel.**

The routing choice rests on a small table of eight page entries. Each entry covers a 16 MB page of the 128 MB processor-owned region. It holds an 8-bit base field and two attribute bits, one suppressing snooping for reads and one for writes. An access that is not snooped is rebased: its top byte is replaced with the page's base field. The rebased address is then compared against a shared boundary value, which decides whether the memory controller or the on-chip bus receives it. An address outside the processor region skips the table entirely and goes to the memory controller untouched.

Only one request is handled at a time. The router captures a request, presents it on the chosen channel and holds it there. It acknowledges the requester in the same cycle that the chosen channel accepts. The page table is loaded through a one-entry-per-cycle write port.

Top module: `snoop_slave_router`

## Requirements
- R1: After reset no output channel is valid, `req_ready` is low, and every page entry has base 0 with both snoop-disable bits clear, so every in-region access is snooped.
- R2: An address whose bits 31:27 are not all zero goes to the memory-controller channel with its address unchanged, whatever the page table holds.
- R3: For an in-region address (bits 31:27 all zero), bits 26:24 pick the page entry that is consulted, and no other entry affects the routing.
- R4: For an in-region read (`req_write` = 0) the page's read snoop-disable bit decides the route. When that bit is 0 the request goes to the snoop channel with its address unchanged.
- R5: For an in-region write (`req_write` = 1) the page's write snoop-disable bit decides the route, independently of the read bit. When the write bit is 0 the request goes to the snoop channel unchanged.
- R6: A non-snooped in-region request leaves with address bits 31:24 equal to the page's base field and bits 23:0 copied from the request.
- R7: A rebased request goes to the memory-controller channel when its base field is less than `mem_bound`, and to the on-chip-bus channel when the base field is greater than or equal to `mem_bound`.
- R8: A captured request appears on exactly one channel one cycle after it is taken. That channel's valid and address stay steady while its ready is low. `req_ready` is high only in the cycle that channel's ready is high, and afterwards all channels are idle.
- R9: A page-table write takes effect for every request captured after the write's clock edge.
- R10: The read/write flag of the request appears unchanged on the channel that carries it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Page-table write strobe |
| cfg_page | input | 3 | Page entry to write |
| cfg_base | input | 8 | Base field to store |
| cfg_rd_nosnoop | input | 1 | Read snoop-disable bit to store |
| cfg_wr_nosnoop | input | 1 | Write snoop-disable bit to store |
| mem_bound | input | 8 | Top-byte boundary: below it goes to memory controller, at or above to on-chip bus |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted by the chosen channel |
| req_addr | input | 32 | Request address |
| req_write | input | 1 | 1 = write, 0 = read |
| io_valid | output | 1 | Snoop channel request valid |
| io_ready | input | 1 | Snoop channel accepts |
| io_addr | output | 32 | Snoop channel address |
| io_write | output | 1 | Snoop channel read/write flag |
| mc_valid | output | 1 | Memory-controller channel request valid |
| mc_ready | input | 1 | Memory-controller channel accepts |
| mc_addr | output | 32 | Memory-controller channel address |
| mc_write | output | 1 | Memory-controller channel read/write flag |
| bus_valid | output | 1 | On-chip-bus channel request valid |
| bus_ready | input | 1 | On-chip-bus channel accepts |
| bus_addr | output | 32 | On-chip-bus channel address |
| bus_write | output | 1 | On-chip-bus channel read/write flag |

## Verification
Two kinds of internal fault show up at the ports within one cycle of the request being taken:

- **Wrong page entry.** A corrupted entry or a wrong page index shows up as a request on the wrong channel, or as a top address byte that differs from the stored base.
- **Wrong capture state.** A fault here shows up as two valid channels at once, as an address that changes while the channel is stalled, or as `req_ready` rising without a channel handshake.

The stalled-channel cases hold ready low for several cycles so that drift in the held request becomes visible before acceptance. The page-table tests rewrite entries between requests, so a write that lands late or on the wrong entry is caught on the very next request.

// File: rtl/snoop_slave_router.sv
module snoop_slave_router #(
  parameter int AW     = 32,
  parameter int PAGE_W = 24,
  parameter int PG_W   = 3,
  parameter int BASE_W = AW - PAGE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [PG_W-1:0]   cfg_page,
  input  logic [BASE_W-1:0] cfg_base,
  input  logic              cfg_rd_nosnoop,
  input  logic              cfg_wr_nosnoop,
  input  logic [BASE_W-1:0] mem_bound,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [AW-1:0]     req_addr,
  input  logic              req_write,
  output logic              io_valid,
  input  logic              io_ready,
  output logic [AW-1:0]     io_addr,
  output logic              io_write,
  output logic              mc_valid,
  input  logic              mc_ready,
  output logic [AW-1:0]     mc_addr,
  output logic              mc_write,
  output logic              bus_valid,
  input  logic              bus_ready,
  output logic [AW-1:0]     bus_addr,
  output logic              bus_write
);
  localparam int NPG = 1 << PG_W;
  localparam int RLSB = PAGE_W + PG_W;

  typedef enum logic [1:0] {TO_IO, TO_MC, TO_BUS} route_t;

  logic [BASE_W-1:0] pg_base [NPG];
  logic [NPG-1:0]    pg_rd_ns, pg_wr_ns;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NPG; i++) pg_base[i] <= '0;
      pg_rd_ns <= '0;
      pg_wr_ns <= '0;
    end else if (cfg_we) begin
      pg_base[cfg_page]  <= cfg_base;
      pg_rd_ns[cfg_page] <= cfg_rd_nosnoop;
      pg_wr_ns[cfg_page] <= cfg_wr_nosnoop;
    end
  end

  wire              in_region = (req_addr[AW-1:RLSB] == '0);
  wire [PG_W-1:0]   pg        = req_addr[RLSB-1:PAGE_W];
  wire              no_snoop  = req_write ? pg_wr_ns[pg] : pg_rd_ns[pg];
  wire [BASE_W-1:0] base      = pg_base[pg];

  route_t        route_n;
  logic [AW-1:0] addr_n;

  always_comb begin
    addr_n = req_addr;
    if (!in_region)     route_n = TO_MC;
    else if (!no_snoop) route_n = TO_IO;
    else begin
      addr_n  = {base, req_addr[PAGE_W-1:0]};
      route_n = (base < mem_bound) ? TO_MC : TO_BUS;
    end
  end

  logic          busy;
  route_t        route_q;
  logic [AW-1:0] addr_q;
  logic          wr_q;

  assign io_valid  = busy && route_q == TO_IO;
  assign mc_valid  = busy && route_q == TO_MC;
  assign bus_valid = busy && route_q == TO_BUS;

  wire sel_ready = (io_valid && io_ready) || (mc_valid && mc_ready) ||
                   (bus_valid && bus_ready);
  assign req_ready = sel_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      route_q <= TO_MC;
      addr_q  <= '0;
      wr_q    <= 1'b0;
    end else if (!busy) begin
      if (req_valid) begin
        busy    <= 1'b1;
        route_q <= route_n;
        addr_q  <= addr_n;
        wr_q    <= req_write;
      end
    end else if (sel_ready) begin
      busy <= 1'b0;
    end
  end

  assign io_addr   = addr_q;
  assign mc_addr   = addr_q;
  assign bus_addr  = addr_q;
  assign io_write  = wr_q;
  assign mc_write  = wr_q;
  assign bus_write = wr_q;
endmodule

module snoop_slave_router_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_ready,
  input logic          io_valid,
  input logic          io_ready,
  input logic [AW-1:0] io_addr,
  input logic          mc_valid,
  input logic          mc_ready,
  input logic [AW-1:0] mc_addr,
  input logic          bus_valid,
  input logic          bus_ready,
  input logic [AW-1:0] bus_addr
);
  assert_one_channel_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({io_valid, mc_valid, bus_valid}));

  assert_ready_handshake_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> ((io_valid && io_ready) || (mc_valid && mc_ready) || (bus_valid && bus_ready)));

  assert_idle_after_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |=> !(io_valid || mc_valid || bus_valid));

  assert_io_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (io_valid && !io_ready) |=> (io_valid && $stable(io_addr)));

  assert_mc_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mc_valid && !mc_ready) |=> (mc_valid && $stable(mc_addr)));

  assert_bus_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_ready) |=> (bus_valid && $stable(bus_addr)));

  assert_snoop_in_region_R4: assert property (@(posedge clk) disable iff (!rst_n)
    io_valid |-> (io_addr[AW-1:27] == '0));
endmodule

bind snoop_slave_router snoop_slave_router_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready),
  .io_valid(io_valid), .io_ready(io_ready), .io_addr(io_addr),
  .mc_valid(mc_valid), .mc_ready(mc_ready), .mc_addr(mc_addr),
  .bus_valid(bus_valid), .bus_ready(bus_ready), .bus_addr(bus_addr)
);

// File: tb/test_snoop_slave_router.sv
module test_snoop_slave_router;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_page = '0;
  logic [7:0]  cfg_base = '0;
  logic        cfg_rd_nosnoop = 1'b0, cfg_wr_nosnoop = 1'b0;
  logic [7:0]  mem_bound = 8'h80;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [31:0] req_addr = '0;
  logic        req_ready;
  logic        io_valid, mc_valid, bus_valid;
  logic        io_ready = 1'b0, mc_ready = 1'b0, bus_ready = 1'b0;
  logic [31:0] io_addr, mc_addr, bus_addr;
  logic        io_write, mc_write, bus_write;

  int checks = 0;
  int fails = 0;

  localparam int CH_IO = 0, CH_MC = 1, CH_BUS = 2;

  always #4 clk = ~clk;

  snoop_slave_router i_snoop_slave_router (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_page(cfg_page),
    .cfg_base(cfg_base), .cfg_rd_nosnoop(cfg_rd_nosnoop),
    .cfg_wr_nosnoop(cfg_wr_nosnoop), .mem_bound(mem_bound),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_write(req_write),
    .io_valid(io_valid), .io_ready(io_ready), .io_addr(io_addr), .io_write(io_write),
    .mc_valid(mc_valid), .mc_ready(mc_ready), .mc_addr(mc_addr), .mc_write(mc_write),
    .bus_valid(bus_valid), .bus_ready(bus_ready), .bus_addr(bus_addr), .bus_write(bus_write)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  task automatic set_page(input logic [2:0] p, input logic [7:0] b,
                          input logic rns, input logic wns);
    @(negedge clk);
    cfg_we = 1'b1; cfg_page = p; cfg_base = b;
    cfg_rd_nosnoop = rns; cfg_wr_nosnoop = wns;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic send(input string req, input logic [31:0] a, input logic wr,
                      input int exp_ch, input logic [31:0] exp_a, input int stall);
    logic [31:0] ch_addr;
    logic        ch_wr;
    int          ch;
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_write = wr;
    @(negedge clk);
    ch = io_valid ? CH_IO : mc_valid ? CH_MC : bus_valid ? CH_BUS : 3;
    check({req, " channel"}, ch, exp_ch);
    check({req, " one channel R8"}, 32'(io_valid + mc_valid + bus_valid), 32'd1);
    ch_addr = (ch == CH_IO) ? io_addr : (ch == CH_MC) ? mc_addr : bus_addr;
    ch_wr   = (ch == CH_IO) ? io_write : (ch == CH_MC) ? mc_write : bus_write;
    check({req, " address"}, ch_addr, exp_a);
    check({req, " write flag R10"}, 32'(ch_wr), 32'(wr));
    for (int s = 0; s < stall; s++) begin
      check({req, " stall no ready R8"}, 32'(req_ready), 32'd0);
      @(negedge clk);
      ch_addr = (ch == CH_IO) ? io_addr : (ch == CH_MC) ? mc_addr : bus_addr;
      check({req, " stall held R8"}, ch_addr, exp_a);
    end
    io_ready = 1'b1; mc_ready = 1'b1; bus_ready = 1'b1;
    #1;
    check({req, " ack R8"}, 32'(req_ready), 32'd1);
    @(posedge clk);
    #1;
    req_valid = 1'b0; io_ready = 1'b0; mc_ready = 1'b0; bus_ready = 1'b0;
    @(negedge clk);
    check({req, " idle after ack R8"}, 32'({io_valid, mc_valid, bus_valid, req_ready}), 32'd0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1 reset valids", 32'({io_valid, mc_valid, bus_valid}), 32'd0);
    check("R1 reset ready", 32'(req_ready), 32'd0);
    send("R1 default snoop read", 32'h0500_1234, 1'b0, CH_IO, 32'h0500_1234, 0);
    send("R1 default snoop write", 32'h0000_0040, 1'b1, CH_IO, 32'h0000_0040, 0);
  endtask

  task automatic t_above();
    set_page(3'd2, 8'h40, 1'b1, 1'b1);
    send("R2 just above region", 32'h0A00_0010, 1'b0, CH_MC, 32'h0A00_0010, 0);
    send("R2 top half write", 32'h8000_0008, 1'b1, CH_MC, 32'h8000_0008, 2);
    send("R2 first above", 32'h0800_0000, 1'b0, CH_MC, 32'h0800_0000, 0);
  endtask

  task automatic t_direction();
    set_page(3'd3, 8'h10, 1'b1, 1'b0);
    send("R4 R6 R7 read rebased", 32'h0312_3456, 1'b0, CH_MC, 32'h1012_3456, 0);
    send("R5 write snooped", 32'h0312_3456, 1'b1, CH_IO, 32'h0312_3456, 0);
    set_page(3'd5, 8'hC0, 1'b0, 1'b1);
    send("R5 R7 write to bus", 32'h05AB_CDEF, 1'b1, CH_BUS, 32'hC0AB_CDEF, 3);
    send("R4 read snooped", 32'h05AB_CDEF, 1'b0, CH_IO, 32'h05AB_CDEF, 3);
  endtask

  task automatic t_bound();
    set_page(3'd6, 8'h80, 1'b1, 1'b1);
    set_page(3'd7, 8'h7F, 1'b1, 1'b1);
    send("R7 base equal bound", 32'h0600_0001, 1'b0, CH_BUS, 32'h8000_0001, 0);
    send("R7 base below bound", 32'h07FF_FFFF, 1'b1, CH_MC, 32'h7FFF_FFFF, 1);
    send("R3 page 2 consulted", 32'h02FF_0000, 1'b0, CH_MC, 32'h40FF_0000, 0);
    send("R3 page 0 untouched", 32'h00FF_0000, 1'b0, CH_IO, 32'h00FF_0000, 0);
  endtask

  task automatic t_rewrite();
    set_page(3'd3, 8'h10, 1'b0, 1'b0);
    send("R9 rewrite to snoop", 32'h0300_0100, 1'b0, CH_IO, 32'h0300_0100, 0);
    set_page(3'd3, 8'hF0, 1'b1, 1'b1);
    send("R9 rewrite to bus", 32'h0300_0100, 1'b1, CH_BUS, 32'hF000_0100, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_above();
    t_direction();
    t_bound();
    t_rewrite();
    repeat (2) @(posedge clk);
    report();
  end
endmodule